// File: doc/BRIEF.md
# Two-Wire Target with 7-bit and 10-bit Addressing

This block is the target side of an I2C link. It watches the clock and data wires through synchronizers. It never drives a wire high. Each wire is either pulled low through an enable output or released. When a header names the block's own address, the block acknowledges it. A configuration input selects whether that address is the 7-bit form or the two-byte 10-bit form. Addressed transfers then read or write a local register space through a byte pointer.

On a write, the first data byte after the header sets the pointer. Each later byte is handed to the local logic as a one-cycle write strobe with the pointer as the index, and the pointer then steps forward. On a read, the block shifts out the byte that the local logic returns for the current pointer, MSB first, and steps the pointer after every byte. The pointer keeps its value across transfers. When the local side deasserts its ready input, the block holds the clock wire low after the acknowledge of an addressed byte. It releases the wire once ready returns. A one-cycle wake pulse marks every completed own-address match.

Top module: `i2c_dual_tgt`

## Requirements
- R1: Both wires are only ever pulled low through `scl_oe`/`sda_oe`. Reset releases both. `sda_oe` changes only while the synchronized clock is low.
- R2: A START (data falls while clock is high) or a STOP (data rises while clock is high) is recognised at any bit position. A STOP in the middle of a byte abandons the transfer, and the next START begins a new header.
- R3: In 7-bit mode (`ten_bit_mode`=0), a first header byte whose bits 7:1 equal `own_addr[6:0]` is acknowledged: data is held low during the ninth clock. Any other header is not acknowledged, and the rest of that transfer is ignored.
- R4: When `own_addr[6:3]` is 0000 or 1111, no 7-bit header is ever acknowledged and no wake pulse is issued.
- R5: In 10-bit mode, the header is the byte 11110, `own_addr[9:8]`, R/W=0, followed by the byte `own_addr[7:0]`. Both bytes are acknowledged. A wrong second byte, or a 7-bit style header, is not acknowledged.
- R6: A 10-bit read header (11110, `own_addr[9:8]`, 1) is acknowledged only after a matching 10-bit write header in the same transfer, followed by a repeated START. Otherwise it is not acknowledged.
- R7: When the R/W bit (bit 0 of the header byte) is 1, the target sends `reg_rdata` for index `reg_idx`, MSB first, one byte per nine clocks.
- R8: The first data byte written after the header loads the pointer. Each later written byte gives one `reg_wr` pulse with `reg_idx` equal to the pointer and `reg_wdata` equal to the byte, then the pointer increments. Every written byte is acknowledged.
- R9: The pointer increments after every byte read, whether the controller acknowledges it or not, and keeps its value into the next transfer.
- R10: A controller NAK after a read byte ends sending. `sda_oe` stays low through any further clocks until the next START.
- R11: After the acknowledge of an addressed byte, while `loc_rdy` is 0, `scl_oe` is held at 1. The clock is released once `loc_rdy` is 1.
- R12: `wake` pulses for exactly one clock on each completed own-address match: the 7-bit header, the second 10-bit write byte, or the 10-bit read header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Clock wire level as seen at the pad |
| sda_i | input | 1 | Data wire level as seen at the pad |
| scl_oe | output | 1 | 1 pulls the clock wire low (stretch) |
| sda_oe | output | 1 | 1 pulls the data wire low |
| ten_bit_mode | input | 1 | 0: 7-bit own address, 1: 10-bit own address |
| own_addr | input | 10 | Own address; bits 6:0 are used in 7-bit mode |
| loc_rdy | input | 1 | Local side ready; 0 requests clock stretching |
| wake | output | 1 | One-cycle pulse on own-address match |
| reg_idx | output | PW | Current register pointer |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Byte to write at `reg_idx` |
| reg_rdata | input | 8 | Byte at `reg_idx`, sampled when a read byte starts |

## Verification
The bench checks the 10-bit read gate in both directions: a read header with no prior selection must be refused, while the same header after a selected write and a repeated START must be accepted. A block that ignored the gate would answer foreign 10-bit reads. The bench places a STOP four bits into a header. A design that kept counting across it would misalign the next header and refuse a valid address. It also keeps clocking after a controller NAK. A target that kept sending would corrupt the wire with stray zero bits there. Pointer continuity across transfers and the NAK-counted increment are checked by a header-only read. A pointer that skipped or repeated a byte would return the neighbouring register.

// File: rtl/i2c_dual_tgt.sv
module i2c_dual_tgt #(
  parameter int PW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic          ten_bit_mode,
  input  logic [9:0]    own_addr,
  input  logic          loc_rdy,
  output logic          wake,
  output logic [PW-1:0] reg_idx,
  output logic          reg_wr,
  output logic [7:0]    reg_wdata,
  input  logic [7:0]    reg_rdata
);

  typedef enum logic [2:0] {S_IDLE, S_HDR1, S_HDR2, S_PTR, S_WDAT, S_RDAT, S_SKIP} st_t;

  logic [SYNC-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p;
  wire scl_s = scl_sh[SYNC-1];
  wire sda_s = sda_sh[SYNC-1];
  wire scl_rise = scl_s & ~scl_p;
  wire scl_fall = ~scl_s & scl_p;
  wire start_c  = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_c   = scl_s & scl_p & ~sda_p & sda_s;

  st_t st;
  logic [7:0] shreg, txsr;
  logic [3:0] bitcnt;
  logic in_ack, first_rd, pend, ten_sel;
  logic [PW-1:0] ptr;

  wire rsv7 = (own_addr[6:3] == 4'b0000) || (own_addr[6:3] == 4'b1111);
  wire m7   = !ten_bit_mode && !rsv7 && (shreg[7:1] == own_addr[6:0]);
  wire m10h = ten_bit_mode && (shreg[7:3] == 5'b11110) && (shreg[2:1] == own_addr[9:8]);
  wire addressed = (st == S_PTR) || (st == S_WDAT) || (st == S_RDAT);

  assign scl_oe  = pend;
  assign reg_idx = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1; sda_sh <= '1; scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC-2:0], sda_i};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; shreg <= '0; txsr <= '0; bitcnt <= '0;
      in_ack <= 1'b0; first_rd <= 1'b0; pend <= 1'b0; ten_sel <= 1'b0;
      ptr <= '0; sda_oe <= 1'b0; wake <= 1'b0; reg_wr <= 1'b0; reg_wdata <= '0;
    end else begin
      wake   <= 1'b0;
      reg_wr <= 1'b0;
      if (reg_wr) ptr <= PW'(ptr + 1'b1);
      if (start_c) begin
        st <= S_HDR1; bitcnt <= '0; in_ack <= 1'b0; sda_oe <= 1'b0;
        pend <= 1'b0; first_rd <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE; ten_sel <= 1'b0; bitcnt <= '0; in_ack <= 1'b0;
        sda_oe <= 1'b0; pend <= 1'b0;
      end else if (st != S_IDLE) begin
        if (pend && loc_rdy) begin
          pend <= 1'b0;
          if (st == S_RDAT) begin
            txsr   <= reg_rdata;
            sda_oe <= ~reg_rdata[7];
          end
        end
        if (scl_rise) begin
          if (!in_ack) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= 4'(bitcnt + 1'b1);
          end else if (st == S_RDAT && !first_rd) begin
            ptr <= PW'(ptr + 1'b1);
            if (sda_s) st <= S_SKIP;
          end
        end
        if (scl_fall) begin
          if (in_ack) begin
            in_ack <= 1'b0; bitcnt <= '0; sda_oe <= 1'b0; first_rd <= 1'b0;
            if (addressed) pend <= 1'b1;
          end else if (bitcnt == 4'd8) begin
            in_ack <= 1'b1;
            sda_oe <= 1'b0;
            case (st)
              S_HDR1: begin
                if (m7) begin
                  sda_oe <= 1'b1; wake <= 1'b1;
                  if (shreg[0]) begin st <= S_RDAT; first_rd <= 1'b1; end
                  else st <= S_PTR;
                end else if (m10h && !shreg[0]) begin
                  sda_oe <= 1'b1; st <= S_HDR2;
                end else if (m10h && ten_sel) begin
                  sda_oe <= 1'b1; wake <= 1'b1; st <= S_RDAT; first_rd <= 1'b1;
                end else begin
                  st <= S_SKIP; ten_sel <= 1'b0;
                end
              end
              S_HDR2: begin
                if (shreg == own_addr[7:0]) begin
                  sda_oe <= 1'b1; wake <= 1'b1; ten_sel <= 1'b1; st <= S_PTR;
                end else begin
                  st <= S_SKIP; ten_sel <= 1'b0;
                end
              end
              S_PTR: begin
                ptr <= PW'(shreg); sda_oe <= 1'b1; st <= S_WDAT;
              end
              S_WDAT: begin
                reg_wr <= 1'b1; reg_wdata <= shreg; sda_oe <= 1'b1;
              end
              default: ;
            endcase
          end else if (st == S_RDAT && bitcnt != 4'd0) begin
            sda_oe <= ~txsr[3'(4'd7 - bitcnt)];
          end
        end
      end
    end
  end

  p_oe_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (!sda_oe && !scl_oe));
  p_sda_clk_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);
  p_skip_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SKIP) |-> !sda_oe);
  p_rsv_nomatch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (ten_bit_mode || !rsv7));
  p_wake_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);
  p_wr_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe && !loc_rdy) |=> scl_oe);

endmodule

// File: tb/sim_i2c_dual_tgt.sv
module sim_i2c_dual_tgt;
  localparam int Q = 8;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic m_scl_lo = 0, m_sda_lo = 0;
  logic scl_oe, sda_oe, ten_bit_mode = 0, loc_rdy = 1, wake, reg_wr;
  logic [9:0] own_addr = 10'h05A;
  logic [7:0] reg_idx, reg_wdata, reg_rdata;
  wire scl_line = !(m_scl_lo || scl_oe);
  wire sda_line = !(m_sda_lo || sda_oe);

  logic [7:0] regs [256];
  logic [7:0] expv [256];
  int wake_n = 0, total = 0, bad = 0;
  assign reg_rdata = regs[reg_idx];

  i2c_dual_tgt u0 (.clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .ten_bit_mode(ten_bit_mode), .own_addr(own_addr),
    .loc_rdy(loc_rdy), .wake(wake), .reg_idx(reg_idx), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  always @(posedge clk) begin
    if (reg_wr) regs[reg_idx] <= reg_wdata;
    if (wake) wake_n <= wake_n + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart;
    m_sda_lo = 0; wq(Q);
    m_scl_lo = 0; while (!scl_line) wq(1); wq(Q);
    m_sda_lo = 1; wq(Q);
    m_scl_lo = 1; wq(Q);
  endtask

  task automatic bstop;
    m_sda_lo = 1; wq(Q);
    m_scl_lo = 0; while (!scl_line) wq(1); wq(Q);
    m_sda_lo = 0; wq(2*Q);
  endtask

  task automatic bitx(input bit b, output bit r, output int h);
    m_sda_lo = !b; wq(Q);
    m_scl_lo = 0; h = 0;
    while (!scl_line) begin wq(1); h++; end
    wq(Q/2); r = sda_line; wq(Q/2);
    m_scl_lo = 1; wq(Q);
  endtask

  task automatic sendb(input logic [7:0] b, output bit ack, output int h0);
    bit r; int h;
    for (int i = 7; i >= 0; i--) begin
      bitx(b[i], r, h);
      if (i == 7) h0 = h;
    end
    bitx(1'b1, r, h);
    ack = !r;
  endtask

  task automatic recvb(input bit nak, output logic [7:0] d);
    bit r; int h;
    for (int i = 0; i < 8; i++) begin bitx(1'b1, r, h); d = {d[6:0], r}; end
    bitx(nak, r, h);
  endtask

  task automatic hdr(input bit ten, input logic [9:0] a, input bit rw, output bit ack);
    int h;
    if (!ten) sendb({a[6:0], rw}, ack, h);
    else begin
      sendb({5'b11110, a[9:8], 1'b0}, ack, h);
      if (ack) sendb(a[7:0], ack, h);
    end
  endtask

  task automatic wr_tx(input bit ten, input logic [7:0] p, input int n);
    bit ack; int h; int w0; logic [7:0] d;
    w0 = wake_n;
    bstart; hdr(ten, own_addr, 1'b0, ack);
    chk(ack, ten ? "R5 header ack" : "R3 header ack", ack, 1);
    sendb(p, ack, h);
    chk(ack, "R8 pointer ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      sendb(d, ack, h);
      expv[8'(p + k)] = d;
      chk(ack, "R8 data ack", ack, 1);
    end
    bstop;
    chk(wake_n == w0 + 1, "R12 one wake per write", wake_n - w0, 1);
    for (int k = 0; k < n; k++)
      chk(regs[8'(p + k)] == expv[8'(p + k)], "R8 register written", regs[8'(p + k)], expv[8'(p + k)]);
  endtask

  task automatic rd_tx(input bit ten, input logic [7:0] p, input int n);
    bit ack; int h; logic [7:0] d;
    bstart; hdr(ten, own_addr, 1'b0, ack);
    sendb(p, ack, h);
    bstart;
    if (ten) sendb({5'b11110, own_addr[9:8], 1'b1}, ack, h);
    else sendb({own_addr[6:0], 1'b1}, ack, h);
    chk(ack, ten ? "R6 10-bit read header ack" : "R7 read header ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      recvb(k == n - 1, d);
      chk(d == expv[8'(p + k)], "R7 read data", d, expv[8'(p + k)]);
    end
    bstop;
  endtask

  initial begin
    bit ack; int h; logic [7:0] d; int w0; bit r;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) begin regs[i] = 8'(i * 7 + 3); expv[i] = 8'(i * 7 + 3); end
    wq(3);
    chk(!scl_oe && !sda_oe && !wake, "R1 reset releases lines", {scl_oe, sda_oe, wake}, 0);
    rst_n = 1; wq(4);

    wr_tx(0, 8'h10, 3);
    rd_tx(0, 8'h10, 3);

    // R9: pointer advanced past NAKed byte; R10: quiet after NAK
    bstart; hdr(0, own_addr, 0, ack); sendb(8'h20, ack, h);
    bstart; sendb({own_addr[6:0], 1'b1}, ack, h);
    recvb(0, d); recvb(1, d);
    recvb(0, d);
    chk(d == 8'hFF, "R10 released after NAK", d, 8'hFF);
    bstop;
    bstart; sendb({own_addr[6:0], 1'b1}, ack, h);
    recvb(1, d); bstop;
    chk(d == expv[8'h22], "R9 pointer kept across transfers", d, expv[8'h22]);

    // R3 mismatch
    w0 = wake_n;
    bstart; sendb({7'h33, 1'b0}, ack, h);
    chk(!ack, "R3 foreign address NAK", ack, 0);
    sendb(8'h40, ack, h); sendb(8'h99, ack, h);
    bstop;
    chk(wake_n == w0, "R12 no wake on foreign", wake_n - w0, 0);
    chk(regs[8'h99] == expv[8'h99] && regs[8'h22] == expv[8'h22], "R3 foreign write ignored", regs[8'h99], expv[8'h99]);

    // R2 STOP mid-byte
    bstart;
    for (int i = 0; i < 4; i++) bitx(own_addr[6 - i], r, h);
    bstop;
    chk(!sda_oe && !scl_oe, "R2 lines released after STOP", sda_oe, 0);
    wr_tx(0, 8'h30, 1);

    // R4 reserved own addresses
    own_addr = 10'h003; w0 = wake_n;
    bstart; sendb({7'h03, 1'b0}, ack, h); bstop;
    chk(!ack, "R4 reserved 0000xxx NAK", ack, 0);
    own_addr = 10'h07C;
    bstart; sendb({7'h7C, 1'b0}, ack, h); bstop;
    chk(!ack, "R4 reserved 1111xxx NAK", ack, 0);
    chk(wake_n == w0, "R4 no wake", wake_n - w0, 0);

    // 10-bit mode
    ten_bit_mode = 1; own_addr = 10'h2A5;
    wr_tx(1, 8'h50, 2);
    rd_tx(1, 8'h50, 2);
    bstart; sendb({5'b11110, 2'b10, 1'b0}, ack, h); sendb(8'hA4, ack, h); bstop;
    chk(!ack, "R5 wrong low byte NAK", ack, 0);
    bstart; sendb({7'h5A, 1'b0}, ack, h); bstop;
    chk(!ack, "R5 7-bit header refused in 10-bit mode", ack, 0);
    bstart; sendb({5'b11110, 2'b10, 1'b1}, ack, h); bstop;
    chk(!ack, "R6 read without selection NAK", ack, 0);

    // R11 stretch
    loc_rdy = 0;
    bstart; hdr(1, own_addr, 0, ack);
    fork
      begin sendb(8'h60, ack, h); end
      begin
        wq(100);
        chk(scl_line == 0 && scl_oe == 1, "R11 clock held while not ready", scl_oe, 1);
        loc_rdy = 1;
      end
    join
    chk(h >= 90, "R11 stretch length", h, 90);
    d = 8'h6D; sendb(d, ack, h); expv[8'h60] = d;
    bstop;
    chk(regs[8'h60] == 8'h6D, "R11 write after stretch", regs[8'h60], 8'h6D);

    // random mix
    for (int it = 0; it < 10; it++) begin
      logic [7:0] p; int n; bit t;
      t = 1'($urandom % 2); p = 8'($urandom); n = 1 + int'($urandom % 3);
      ten_bit_mode = t; own_addr = t ? 10'h2A5 : 10'h05A;
      wr_tx(t, p, n);
      rd_tx(t, p, n);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule